// File: doc/BRIEF.md
# Predicated Vector Immediate Shifter

The block performs a lane-wise logical right shift on a 128-bit vector operand, with each lane gated by a byte-granular predicate mask. A single 7-bit control word sets both the lane width and the shift count. The upper four bits of the control word form a size tag. The position of the highest set bit in that tag picks a lane width of 8, 16, 32 or 64 bits. The count is then found by subtracting the whole 7-bit word from twice the lane width, so every legal word maps to a count between 1 and the lane width.

Lanes whose predicate is active are shifted with zero fill. All other lanes keep the operand value. The assembled vector is loaded into a result register, where it takes the place of the operand. A size tag of zero is an undefined encoding: it raises a flag and leaves the result register untouched.

The datapath computes every lane width in parallel and selects one at the end. Because of this, the latency is one cycle for every operand, predicate and control value.

Top module: `vshr_top`

## Requirements
- R1: The control word is {tag[3:0], imm[2:0]}, with tag = ctl[6:3]. When op_valid is high with tag = 0, res_bad is 1 after the next rising edge and res_vec keeps its previous value.
- R2: The lane width follows the highest set bit of tag: tag 1 gives 8 bits, 2..3 give 16, 4..7 give 32 and 8..15 give 64. Lane k covers res_vec bits [k*W+W-1 : k*W].
- R3: The shift count is 2*W minus the unsigned value of the full 7-bit control word, which is always between 1 and W.
- R4: The shift is logical, so the vacated high bits of each shifted lane are zero.
- R5: A lane is active when op_pred[k*W/8] is 1. Predicate bit i belongs to byte i of the vector. The other predicate bits inside a lane have no effect.
- R6: An inactive lane shows its unchanged operand bits in res_vec.
- R7: A count equal to W makes an active lane all zeros.
- R8: res_vec and res_bad change only on the rising edge after a cycle with op_valid high. A defined encoding clears res_bad. With op_valid low, both outputs hold their values.
- R9: After reset, res_vec is zero and res_bad is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation strobe |
| op_vec | input | 128 | Vector operand |
| op_pred | input | 16 | Predicate mask, one bit per byte |
| op_ctl | input | 7 | Size tag and immediate, {tag, imm} |
| res_vec | output | 128 | Registered result vector |
| res_bad | output | 1 | Undefined-encoding flag |

## Verification
The only state is the result register and the flag. A fault in decode, predicate selection or the width multiplexer therefore shows up as a wrong lane value in res_vec on the first rising edge after the strobe. A fault in the hold path shows as a change in res_vec or res_bad on an edge with no strobe, or after an undefined encoding. The sweep drives every one of the 128 control words against several operand and predicate patterns, so every decode path reaches the outputs within one cycle of its stimulus.

// File: rtl/vshr_pkg.sv
package vshr_pkg;

   typedef enum logic [1:0] {
      ESZ_B8  = 2'd0,
      ESZ_H16 = 2'd1,
      ESZ_W32 = 2'd2,
      ESZ_D64 = 2'd3
   } esz_e;

   localparam int unsigned NUM_ESZ = 4;
   localparam int unsigned MIN_EW  = 8;

   // Width code from the highest set bit of the size tag.
   function automatic esz_e tag_to_esz(input logic [3:0] tag);
      esz_e r;
      casez (tag)
         4'b1???: r = ESZ_D64;
         4'b01??: r = ESZ_W32;
         4'b001?: r = ESZ_H16;
         default: r = ESZ_B8;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/vshr_decode.sv
module vshr_decode
   import vshr_pkg::*;
#(
   parameter int unsigned CTL_W = 7,
   parameter int unsigned TAG_W = 4,
   parameter int unsigned SH_W  = 7
) (
   input  logic [CTL_W-1:0] ctl,
   output esz_e             esz,
   output logic [SH_W-1:0]  shamt,
   output logic             undef
);
   localparam int unsigned IMM_W = CTL_W - TAG_W;
   localparam int unsigned DW    = CTL_W + 1;

   if (TAG_W != 4) begin : g_bad_tag
      $error("vshr_decode: size tag must be 4 bits wide");
   end
   if (SH_W > DW) begin : g_bad_sh
      $error("vshr_decode: shift field wider than difference");
   end

   logic [TAG_W-1:0] tag;
   logic [DW-1:0]    twice_ew;
   logic [DW-1:0]    diff;

   always_comb begin
      tag      = ctl[CTL_W-1:IMM_W];
      undef    = (tag == '0);
      esz      = tag_to_esz(tag);
      twice_ew = DW'(2 * MIN_EW) << esz;
      diff     = twice_ew - {1'b0, ctl};
      shamt    = diff[SH_W-1:0];
   end

endmodule

// File: rtl/vshr_elem.sv
module vshr_elem #(
   parameter int unsigned EW   = 8,
   parameter int unsigned SH_W = 7
) (
   input  logic [EW-1:0]   din,
   input  logic [SH_W-1:0] shamt,
   input  logic            active,
   output logic [EW-1:0]   dout
);
   logic [EW-1:0] shifted;

   // A count of EW or more yields zero under SV shift rules; no wrap.
   always_comb begin
      shifted = din >> shamt;
      dout    = active ? shifted : din;
   end

endmodule

// File: rtl/vshr_layer.sv
module vshr_layer #(
   parameter int unsigned VEC_W  = 128,
   parameter int unsigned EW     = 8,
   parameter int unsigned SH_W   = 7,
   parameter int unsigned BYTE_W = 8
) (
   input  logic [VEC_W-1:0]        vec,
   input  logic [VEC_W/BYTE_W-1:0] pred,
   input  logic [SH_W-1:0]         shamt,
   output logic [VEC_W-1:0]        out
);
   localparam int unsigned NELEM    = VEC_W / EW;
   localparam int unsigned BYTES_PE = EW / BYTE_W;

   if (VEC_W % EW != 0) begin : g_bad_div
      $error("vshr_layer: vector width not a multiple of lane width");
   end

   for (genvar e = 0; e < NELEM; e++) begin : g_elem
      vshr_elem #(
         .EW   (EW),
         .SH_W (SH_W)
      ) u_elem (
         .din    (vec[e*EW +: EW]),
         .shamt  (shamt),
         .active (pred[e*BYTES_PE]),
         .dout   (out[e*EW +: EW])
      );
   end

endmodule

// File: rtl/vshr_top.sv
module vshr_top
   import vshr_pkg::*;
#(
   parameter int unsigned VEC_W  = 128,
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned CTL_W  = 7,
   parameter int unsigned TAG_W  = 4,
   parameter int unsigned PRED_W = VEC_W / BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [VEC_W-1:0]  op_vec,
   input  logic [PRED_W-1:0] op_pred,
   input  logic [CTL_W-1:0]  op_ctl,
   output logic [VEC_W-1:0]  res_vec,
   output logic              res_bad
);
   localparam int unsigned MAX_EW = MIN_EW << (NUM_ESZ - 1);
   localparam int unsigned SH_W   = $clog2(MAX_EW) + 1;

   if (VEC_W % MAX_EW != 0) begin : g_bad_vec
      $error("vshr_top: vector width must be a multiple of the widest lane");
   end
   if (PRED_W * BYTE_W != VEC_W) begin : g_bad_pred
      $error("vshr_top: predicate needs one bit per byte");
   end
   if (CTL_W != TAG_W + 3) begin : g_bad_ctl
      $error("vshr_top: control word must be tag plus 3-bit immediate");
   end

   esz_e            esz;
   logic [SH_W-1:0] shamt;
   logic            undef;
   logic [VEC_W-1:0] cand [NUM_ESZ];
   logic [VEC_W-1:0] sel_vec;

   vshr_decode #(
      .CTL_W (CTL_W),
      .TAG_W (TAG_W),
      .SH_W  (SH_W)
   ) u_decode (
      .ctl   (op_ctl),
      .esz   (esz),
      .shamt (shamt),
      .undef (undef)
   );

   // One layer per lane width; all run every cycle for fixed timing.
   for (genvar s = 0; s < NUM_ESZ; s++) begin : g_layer
      vshr_layer #(
         .VEC_W  (VEC_W),
         .EW     (MIN_EW << s),
         .SH_W   (SH_W),
         .BYTE_W (BYTE_W)
      ) u_layer (
         .vec   (op_vec),
         .pred  (op_pred),
         .shamt (shamt),
         .out   (cand[s])
      );
   end

   always_comb begin
      sel_vec = cand[esz];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_vec <= '0;
         res_bad <= 1'b0;
      end else if (op_valid) begin
         res_bad <= undef;
         if (!undef) begin
            res_vec <= sel_vec;
         end
      end
   end

endmodule

// File: rtl/vshr_chk.sv
module vshr_chk #(
   parameter int unsigned VEC_W  = 128,
   parameter int unsigned PRED_W = 16,
   parameter int unsigned CTL_W  = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic [VEC_W-1:0]  op_vec,
   input logic [PRED_W-1:0] op_pred,
   input logic [CTL_W-1:0]  op_ctl,
   input logic [VEC_W-1:0]  res_vec,
   input logic              res_bad
);
   logic tag_zero;
   assign tag_zero = (op_ctl[CTL_W-1:CTL_W-4] == 4'd0);

   assert_undef_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && tag_zero |=> res_bad);

   assert_undef_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && tag_zero |=> $stable(res_vec));

   assert_defined_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && !tag_zero |=> !res_bad);

   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> $stable(res_vec) && $stable(res_bad));

   assert_inactive_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && op_ctl[CTL_W-1:CTL_W-4] == 4'd1 && !op_pred[0]
      |=> res_vec[7:0] == $past(op_vec[7:0]));

   assert_full_width_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && op_ctl == CTL_W'(8) && op_pred[0] |=> res_vec[7:0] == 8'd0);

   assert_zero_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && op_ctl[CTL_W-1] && op_pred[0] |=> !res_vec[63]);

endmodule

bind vshr_top vshr_chk #(
   .VEC_W  (VEC_W),
   .PRED_W (PRED_W),
   .CTL_W  (CTL_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .op_valid (op_valid),
   .op_vec   (op_vec),
   .op_pred  (op_pred),
   .op_ctl   (op_ctl),
   .res_vec  (res_vec),
   .res_bad  (res_bad)
);

// File: tb/tb_vshr_top.sv
module tb_vshr_top;
   logic         clk;
   logic         rst_n;
   logic         op_valid;
   logic [127:0] op_vec;
   logic [15:0]  op_pred;
   logic [6:0]   op_ctl;
   logic [127:0] res_vec;
   logic         res_bad;

   int checks;
   int errors;
   bit done;
   logic [127:0] exp_vec;
   logic         exp_bad;

   vshr_top dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_valid (op_valid),
      .op_vec   (op_vec),
      .op_pred  (op_pred),
      .op_ctl   (op_ctl),
      .res_vec  (res_vec),
      .res_bad  (res_bad)
   );

   initial clk = 1'b0;
   always #2.5 clk = ~clk;

   function automatic int lane_w(input logic [6:0] c);
      int t;
      t = int'(c[6:3]);
      if (t >= 8) return 64;
      if (t >= 4) return 32;
      if (t >= 2) return 16;
      return 8;
   endfunction

   function automatic logic [127:0] model(input logic [127:0] v,
                                          input logic [15:0] p,
                                          input logic [6:0] c);
      int ew;
      int sh;
      logic [127:0] r;
      logic [63:0] el;
      logic [63:0] m;
      ew = lane_w(c);
      sh = 2 * ew - int'(c);
      m  = (ew == 64) ? {64{1'b1}} : ((64'd1 << ew) - 64'd1);
      r  = '0;
      for (int e = 0; e < 128 / ew; e++) begin
         el = 64'(v >> (e * ew)) & m;
         if (p[e * ew / 8]) el = el >> sh;
         r = r | (128'(el) << (e * ew));
      end
      return r;
   endfunction

   task automatic check_vec(input string req, input logic [127:0] exp);
      checks++;
      if (res_vec !== exp) begin
         errors++;
         $display("FAIL %s res_vec actual=%h expected=%h", req, res_vec, exp);
      end
   endtask

   task automatic check_bad(input string req, input logic exp);
      checks++;
      if (res_bad !== exp) begin
         errors++;
         $display("FAIL %s res_bad actual=%b expected=%b", req, res_bad, exp);
      end
   endtask

   // Drive on a falling edge; the result is latched on the following rising edge
   // and sampled on the next falling edge.
   task automatic run_op(input string req, input logic [127:0] v,
                         input logic [15:0] p, input logic [6:0] c);
      @(negedge clk);
      op_valid = 1'b1;
      op_vec   = v;
      op_pred  = p;
      op_ctl   = c;
      if (c[6:3] == 4'd0) begin
         exp_bad = 1'b1;
      end else begin
         exp_bad = 1'b0;
         exp_vec = model(v, p, c);
      end
      @(negedge clk);
      op_valid = 1'b0;
      check_vec(req, exp_vec);
      check_bad((c[6:3] == 4'd0) ? "R1" : "R8", exp_bad);
   endtask

   function automatic logic [127:0] rnd128();
      return {$urandom(), $urandom(), $urandom(), $urandom()};
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [15:0] pats [5];
      string       tags [5];
      checks   = 0;
      errors   = 0;
      done     = 1'b0;
      rst_n    = 1'b0;
      op_valid = 1'b0;
      op_vec   = '0;
      op_pred  = '0;
      op_ctl   = '0;
      exp_vec  = '0;
      exp_bad  = 1'b0;
      repeat (3) @(negedge clk);
      // R9: reset state
      check_vec("R9", '0);
      check_bad("R9", 1'b0);
      rst_n = 1'b1;

      // R2 / R3: explicit lane widths and counts
      run_op("R2", 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 16'hFFFF, 7'd15);
      check_vec("R2", {16{8'h7F}});
      run_op("R2", 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 16'hFFFF, 7'd31);
      check_vec("R2", {8{16'h7FFF}});
      run_op("R3", 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 16'hFFFF, 7'd32);
      check_vec("R7", '0);
      run_op("R3", {2{64'h8000_0000_0000_0000}}, 16'hFFFF, 7'd65);
      check_vec("R3", {2{64'h0000_0000_0000_0001}});

      // R5: only non-lowest predicate bits of each 64-bit lane set
      run_op("R5", {2{64'hF0F0_F0F0_F0F0_F0F0}}, 16'hFEFE, 7'd127);
      check_vec("R5", {2{64'hF0F0_F0F0_F0F0_F0F0}});

      // R1: undefined encoding keeps the previous result
      exp_vec = model({2{64'h1234_5678_9ABC_DEF0}}, 16'hFFFF, 7'd96);
      run_op("R3", {2{64'h1234_5678_9ABC_DEF0}}, 16'hFFFF, 7'd96);
      run_op("R1", rnd128(), 16'hFFFF, 7'd5);

      // R8: idle cycle with changing inputs holds both outputs
      @(negedge clk);
      op_vec  = rnd128();
      op_ctl  = 7'd40;
      op_pred = 16'hFFFF;
      @(negedge clk);
      check_vec("R8", exp_vec);
      check_bad("R8", 1'b1);

      // Sweep every control word against several patterns
      pats[0] = 16'hFFFF; tags[0] = "R3";
      pats[1] = 16'hFFFF; tags[1] = "R4";
      pats[2] = 16'h5555; tags[2] = "R5";
      pats[3] = 16'hAAAA; tags[3] = "R6";
      pats[4] = 16'h0000; tags[4] = "R6";
      for (int c = 0; c < 128; c++) begin
         for (int k = 0; k < 5; k++) begin
            string lbl;
            lbl = tags[k];
            if (c[6:3] == 4'd0) lbl = "R1";
            else if (2 * lane_w(7'(c)) - c == lane_w(7'(c)) && k < 2) lbl = "R7";
            run_op(lbl, (k == 1) ? {128{1'b1}} : rnd128(), pats[k], 7'(c));
         end
      end

      // R9: reset clears a non-zero result
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check_vec("R9", '0);
      check_bad("R9", 1'b0);
      finish_run();
   end

endmodule